// File: doc/BRIEF.md
# Dual-Bank Interrupt Flag Controller

This block gathers six one-cycle event pulses from a real-time-clock style peripheral into flag registers. Software reads and writes these registers over a small synchronous parallel register bus. It also drives one active-low interrupt request line. Three events (periodic, alarm, update-done) go into a primary flag register that clears itself when software reads it. The other three (wake, kickstart, RAM-clear) go into an extended flag register that changes only when software writes zeros to it. Each group has its own enable register.

A flag records its event whatever its enable holds, so software can poll the flags with interrupts off. A read of the primary flag register captures the flags and a summary bit when the read begins, and holds that value for as long as the strobe stays high. An event that lands during such a read is held aside and becomes visible only after the read has completed. The summary bit is 1 exactly while the request line is asserted.

Top module: `irq_flag_ctrl`

## Requirements
- R1: A flag sets on the clock edge that samples its event pulse, whether or not its enable bit is set.
- R2: A read of address 1 returns bit 7 = summary, bit 6 = periodic, bit 5 = alarm, bit 4 = update-done, with bits 3:0 always 0; every set flag is returned together in one read.
- R3: During a read strobe of address 1 (cs and rd high) held for several cycles, rdata keeps the value shown in the strobe's first cycle, even when events arrive.
- R4: Every primary flag returned by a read is cleared on the clock edge that follows the cycle in which the strobe is low again.
- R5: An event that arrives while a primary read strobe is high is not lost; its flag is set on the same edge that clears the read flags.
- R6: The extended flag register at address 2 (bit 2 = wake, bit 1 = kickstart, bit 0 = RAM-clear, bits 7:3 read 0) is unchanged by reads; a write clears each bit written 0 and leaves each bit written 1 as it was.
- R7: If an extended event and a write that clears its bit fall in the same cycle, the flag ends up set.
- R8: irq_n is low exactly when some flag and its enable are both set; primary enables sit at address 0 bits 6:4 and extended enables at address 3 bits 2:0, with the same bit order as the flags.
- R9: Writing an enable bit whose flag is already set drives irq_n low in the cycle after the write edge.
- R10: The summary bit reads 1 exactly when irq_n is low; set flags whose enables are clear do not set it.
- R11: After reset every flag and enable is 0, irq_n is high and all registers read 0.
- R12: Writes to address 1 have no effect on the primary flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Register select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while cs and rd are high |
| ev_alarm | input | 1 | Alarm event pulse |
| ev_periodic | input | 1 | Periodic event pulse |
| ev_update | input | 1 | Update-done event pulse |
| ev_wake | input | 1 | Wake event pulse |
| ev_kick | input | 1 | Kickstart event pulse |
| ev_ramclr | input | 1 | RAM-clear event pulse |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A wrong flag, pending or snapshot state can be observed at the ports in two places. irq_n shows it in the first cycle after the faulty edge when the matching enable is set. Reading the flag register shows it when the enable is clear. A lost pending event or a bad snapshot shows up only one read later: the first read looks correct, and the second read has a missing or stale bit. The directed scenarios therefore follow every clearing read with a second read and an irq_n sample. They also drive events inside a multi-cycle read so that the deferral path is exercised.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int NUM_PRI = 3;
    localparam int NUM_EXT = 3;

    // register addresses
    localparam logic [ADDR_W-1:0] ADDR_PEN   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_PFLAG = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_XFLAG = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_XEN   = 2'd3;

    // field placement inside the data byte
    localparam int PRI_LSB = 4;
    localparam int SUM_BIT = DATA_W - 1;
    localparam int EXT_LSB = 0;

    typedef logic [NUM_PRI-1:0] pri_vec_t;
    typedef logic [NUM_EXT-1:0] ext_vec_t;

    typedef struct packed {
        pri_vec_t pen;
        ext_vec_t xen;
    } en_regs_t;
endpackage

// File: rtl/pri_flag_unit.sv
module pri_flag_unit #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_stb,
    input  logic [N-1:0] ev,
    input  logic         sum_live,
    output logic [N-1:0] flag,
    output logic [N-1:0] snap,
    output logic         snap_sum,
    output logic         busy
);
    typedef struct packed {
        logic         busy;
        logic         snap_sum;
        logic [N-1:0] flag;
        logic [N-1:0] snap;
        logic [N-1:0] pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_stb) begin
            // first cycle of the read: freeze what the bus sees
            if (!st_q.busy) begin
                st_d.snap     = st_q.flag;
                st_d.snap_sum = sum_live;
            end
            st_d.busy = 1'b1;
            st_d.pend = st_q.pend | ev;
        end else if (st_q.busy) begin
            // read finished: drop returned bits, release held events
            st_d.flag = (st_q.flag & ~st_q.snap) | st_q.pend | ev;
            st_d.pend = '0;
            st_d.busy = 1'b0;
        end else begin
            st_d.flag = st_q.flag | ev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag     = st_q.flag;
    assign snap     = st_q.snap;
    assign snap_sum = st_q.snap_sum;
    assign busy     = st_q.busy;
endmodule

// File: rtl/ext_flag_unit.sv
module ext_flag_unit #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  logic [N-1:0] keep,
    input  logic [N-1:0] ev,
    output logic [N-1:0] flag
);
    logic [N-1:0] flag_d, flag_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            flag_d[i] = flag_q[i];
            if (wr_stb && !keep[i]) flag_d[i] = 1'b0;
            if (ev[i])              flag_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
    parameter int NP = 3,
    parameter int NX = 3
) (
    input  logic [NP-1:0] pflag,
    input  logic [NP-1:0] pen,
    input  logic [NX-1:0] xflag,
    input  logic [NX-1:0] xen,
    output logic          active
);
    always_comb begin
        active = (|(pflag & pen)) | (|(xflag & xen));
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ev_alarm,
    input  logic              ev_periodic,
    input  logic              ev_update,
    input  logic              ev_wake,
    input  logic              ev_kick,
    input  logic              ev_ramclr,
    output logic              irq_n
);
    en_regs_t en_d, en_q;
    pri_vec_t pflag_w, psnap_w, pev_w;
    ext_vec_t xflag_w, xev_w;
    logic     psum_snap_w, pbusy_w, irq_act_w;
    logic     prd_stb, xwr_stb;

    assign pev_w   = {ev_periodic, ev_alarm, ev_update};
    assign xev_w   = {ev_wake, ev_kick, ev_ramclr};
    assign prd_stb = cs && rd && (addr == ADDR_PFLAG);
    assign xwr_stb = cs && wr && (addr == ADDR_XFLAG);

    pri_flag_unit #(.N(NUM_PRI)) pri_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_stb   (prd_stb),
        .ev       (pev_w),
        .sum_live (irq_act_w),
        .flag     (pflag_w),
        .snap     (psnap_w),
        .snap_sum (psum_snap_w),
        .busy     (pbusy_w)
    );

    ext_flag_unit #(.N(NUM_EXT)) ext_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (xwr_stb),
        .keep   (wdata[EXT_LSB +: NUM_EXT]),
        .ev     (xev_w),
        .flag   (xflag_w)
    );

    irq_combine #(.NP(NUM_PRI), .NX(NUM_EXT)) comb_i (
        .pflag  (pflag_w),
        .pen    (en_q.pen),
        .xflag  (xflag_w),
        .xen    (en_q.xen),
        .active (irq_act_w)
    );

    // enable registers
    always_comb begin
        en_d = en_q;
        if (cs && wr && addr == ADDR_PEN) en_d.pen = wdata[PRI_LSB +: NUM_PRI];
        if (cs && wr && addr == ADDR_XEN) en_d.xen = wdata[EXT_LSB +: NUM_EXT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    // read mux
    always_comb begin
        rdata = '0;
        if (cs && rd) begin
            unique case (addr)
                ADDR_PEN:   rdata[PRI_LSB +: NUM_PRI] = en_q.pen;
                ADDR_PFLAG: begin
                    if (pbusy_w) begin
                        rdata[PRI_LSB +: NUM_PRI] = psnap_w;
                        rdata[SUM_BIT]            = psum_snap_w;
                    end else begin
                        rdata[PRI_LSB +: NUM_PRI] = pflag_w;
                        rdata[SUM_BIT]            = irq_act_w;
                    end
                end
                ADDR_XFLAG: rdata[EXT_LSB +: NUM_EXT] = xflag_w;
                ADDR_XEN:   rdata[EXT_LSB +: NUM_EXT] = en_q.xen;
                default:    rdata = '0;
            endcase
        end
    end

    assign irq_n = ~irq_act_w;
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs,
    input logic       rd,
    input logic       wr,
    input logic [1:0] addr,
    input logic [7:0] rdata,
    input logic       ev_alarm,
    input logic       ev_wake,
    input logic       irq_n,
    input logic [2:0] pflag,
    input logic [2:0] xflag,
    input logic [2:0] pen,
    input logic [2:0] xen
);
    logic pstb, xwr;
    assign pstb = cs && rd && (addr == 2'd1);
    assign xwr  = cs && wr && (addr == 2'd2);

    // R1
    alarm_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_alarm && !pstb) |=> pflag[1]);

    // R3
    read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstb && $past(pstb)) |-> $stable(rdata));

    // R6
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xflag[2] && !xwr) |=> xflag[2]);

    // R6
    ext_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xflag[2]) |-> $past(ev_wake));

    // R8
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ((pen != 3'b000) || (xen != 3'b000)));

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> irq_n);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .rd       (rd),
    .wr       (wr),
    .addr     (addr),
    .rdata    (rdata),
    .ev_alarm (ev_alarm),
    .ev_wake  (ev_wake),
    .irq_n    (irq_n),
    .pflag    (pflag_w),
    .xflag    (xflag_w),
    .pen      (en_q.pen),
    .xen      (en_q.xen)
);

// File: tb/irq_flag_ctrl_tb_top.sv
module irq_flag_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ev_alarm = 0, ev_periodic = 0, ev_update = 0;
    logic       ev_wake = 0, ev_kick = 0, ev_ramclr = 0;
    logic       irq_n;
    int         checks = 0;
    int         failures = 0;

    always #10 clk = ~clk;

    irq_flag_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ev_alarm(ev_alarm),
        .ev_periodic(ev_periodic), .ev_update(ev_update), .ev_wake(ev_wake),
        .ev_kick(ev_kick), .ev_ramclr(ev_ramclr), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [1:0] a, input int hold, output logic [7:0] d);
        @(negedge clk);
        cs = 1; rd = 1; addr = a;
        #2 d = rdata;
        for (int i = 1; i < hold; i++) @(negedge clk);
        @(negedge clk);
        cs = 0; rd = 0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        cs = 1; wr = 1; addr = a; wdata = v;
        @(negedge clk);
        cs = 0; wr = 0;
    endtask

    // mask order: {periodic, alarm, update, wake, kick, ramclr}
    task automatic pulse(input logic [5:0] m);
        @(negedge clk);
        {ev_periodic, ev_alarm, ev_update, ev_wake, ev_kick, ev_ramclr} = m;
        @(negedge clk);
        {ev_periodic, ev_alarm, ev_update, ev_wake, ev_kick, ev_ramclr} = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R11 irq_n", {7'd0, irq_n}, 8'h01);
        bus_read(2'd1, 1, d); check("R11 pflag", d, 8'h00);
        bus_read(2'd2, 1, d); check("R11 xflag", d, 8'h00);
        bus_read(2'd0, 1, d); check("R11 pen", d, 8'h00);
    endtask

    task automatic t_poll();
        logic [7:0] d;
        pulse(6'b011000);
        #2 check("R1 irq_n stays high", {7'd0, irq_n}, 8'h01);
        bus_read(2'd1, 1, d); check("R2 R10 poll read", d, 8'h30);
        bus_read(2'd1, 1, d); check("R4 cleared after read", d, 8'h00);
    endtask

    task automatic t_midread();
        logic [7:0] d;
        pulse(6'b100000);
        @(negedge clk); cs = 1; rd = 1; addr = 2'd1;
        #2 check("R3 first cycle", rdata, 8'h40);
        @(negedge clk); ev_alarm = 1;
        #2 check("R3 event cycle", rdata, 8'h40);
        @(negedge clk); ev_alarm = 0;
        #2 check("R3 after event", rdata, 8'h40);
        @(negedge clk); cs = 0; rd = 0;
        bus_read(2'd1, 1, d); check("R5 pending applied", d, 8'h20);
        bus_read(2'd1, 1, d); check("R4 pending cleared", d, 8'h00);
    endtask

    task automatic t_ext();
        logic [7:0] d;
        pulse(6'b000110);
        bus_read(2'd2, 1, d); check("R1 xflag set", d, 8'h06);
        bus_read(2'd1, 1, d); check("R6 pflag read", d, 8'h00);
        bus_read(2'd2, 2, d); check("R6 xflag survives reads", d, 8'h06);
        bus_write(2'd2, 8'hFD);
        bus_read(2'd2, 1, d); check("R6 write-zero clear", d, 8'h04);
        bus_write(2'd2, 8'hFF);
        bus_read(2'd2, 1, d); check("R6 write-one no effect", d, 8'h04);
        @(negedge clk);
        cs = 1; wr = 1; addr = 2'd2; wdata = 8'h00; ev_kick = 1;
        @(negedge clk);
        cs = 0; wr = 0; ev_kick = 0;
        bus_read(2'd2, 1, d); check("R7 event beats clear", d, 8'h02);
        bus_write(2'd2, 8'h00);
        bus_read(2'd2, 1, d); check("R6 all cleared", d, 8'h00);
    endtask

    task automatic t_late_enable();
        logic [7:0] d;
        pulse(6'b000001);
        #2 check("R8 no enable no irq", {7'd0, irq_n}, 8'h01);
        bus_write(2'd3, 8'h01);
        #2 check("R9 late enable irq", {7'd0, irq_n}, 8'h00);
        bus_read(2'd1, 1, d); check("R10 summary from ext", d, 8'h80);
        bus_write(2'd2, 8'h00);
        #2 check("R8 irq released", {7'd0, irq_n}, 8'h01);
        bus_write(2'd3, 8'h00);
    endtask

    task automatic t_pri_irq();
        logic [7:0] d;
        bus_write(2'd0, 8'h20);
        bus_read(2'd0, 1, d); check("R8 pen readback", d, 8'h20);
        pulse(6'b010000);
        #2 check("R8 alarm irq", {7'd0, irq_n}, 8'h00);
        bus_read(2'd1, 1, d); check("R2 R10 summary read", d, 8'hA0);
        @(negedge clk);
        #2 check("R4 R8 irq after clear", {7'd0, irq_n}, 8'h01);
        bus_write(2'd0, 8'h00);
    endtask

    task automatic t_ro();
        logic [7:0] d;
        pulse(6'b001000);
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, 1, d); check("R12 write ignored", d, 8'h10);
        bus_read(2'd1, 1, d); check("R4 final clear", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_poll();
        t_midread();
        t_ext();
        t_late_enable();
        t_pri_irq();
        t_ro();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule